// File: doc/BRIEF.md
# Integer Execute Unit with Branch Resolution

This block is the execute stage of a small 32-bit processor with 16-bit instructions. Each issued instruction arrives already decoded. It carries the 6-bit opcode, the values and indices of its two register operands, the immediate field and the address of the instruction. The unit returns a registered result bundle. That bundle holds up to two register write-backs, each with its own index, plus a branch-taken flag with its target address and a divide-by-zero flag.

Logic, add, subtract, move and shift operations finish one cycle after issue. The iterative unsigned multiply and divide take one step per cycle. While they run, `busy` is held high and any new issue is refused. The 64-bit product, or the quotient and remainder pair, goes back into the two operand registers together.

Branches compare one register, read as a signed value, against zero. The target comes either from a second register or from the instruction address plus a scaled signed offset. A call also returns the address of the following instruction for the link register.

Top module: `rx_exec_unit`

## Requirements
- R1: After reset `done`, `busy`, `wr0_en`, `wr1_en`, `br_taken` and `div_zero` are all low. Every result bundle is valid only in the one cycle where `done` is high.
- R2: Opcodes 0x20 ADD, 0x21 SUB, 0x22 AND, 0x23 OR, 0x24 XOR, 0x25 NOT (~rb) and 0x2D MOV (rb) complete with `done` one cycle after `start`, writing to index `ra_idx` (`wr0`). The forms 0x28 ADD, 0x29 SUB and 0x2A AND, which have opcode bit 3 set, use the zero-extended `imm[4:0]` in place of rb.
- R3: 0x26/0x2E shift ra left and 0x27/0x2F shift ra right logically. The amount is the low 5 bits of rb, or `imm[4:0]` in the forms with bit 3 set.
- R4: 0x2B MUL forms the unsigned 64-bit product ra*rb. It writes the upper half to `ra_idx` through `wr0` and the lower half to `rb_idx` through `wr1`, both in the same `done` cycle. `busy` is high from the cycle after issue until that cycle, and `busy` and `done` are never high together.
- R5: 0x2C DIV with a nonzero rb writes the unsigned quotient ra/rb to `ra_idx` (`wr0`) and the remainder to `rb_idx` (`wr1`).
- R6: DIV with rb equal to zero raises `div_zero` together with `done` one cycle after issue, and neither write enable is set.
- R7: The conditional branches are 0x10 zero, 0x11 nonzero, 0x12 negative, 0x13 positive, 0x14 not positive and 0x15 not negative, all judging ra as signed. The target is rb. The forms 0x18..0x1D take instead the instruction address plus the sign-extended `imm[4:0]` times 2. A branch never writes a register.
- R8: 0x16 always branches to rb, and 0x1E always branches to the instruction address plus the sign-extended `imm[9:0]` times 2, with no write.
- R9: 0x17 CALL branches to rb, and 0x1F CALL branches to the instruction address plus the sign-extended `imm[4:0]` times 2. Both write the instruction address plus 2 to `ra_idx` through `wr0`.
- R10: A `start` seen while `busy` is high is ignored. The running operation finishes with its own results, and no extra `done` follows.
- R11: Any opcode outside the ones listed completes with `done` and no write, branch or exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue one decoded instruction |
| op | input | 6 | Opcode |
| ra_val | input | 32 | Value of operand register a |
| rb_val | input | 32 | Value of operand register b |
| ra_idx | input | 5 | Index of register a |
| rb_idx | input | 5 | Index of register b |
| imm | input | 10 | Immediate field (low 5 bits for short forms) |
| pc | input | 32 | Address of the issued instruction |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | Result bundle valid this cycle |
| wr0_en | output | 1 | First write-back enable |
| wr0_idx | output | 5 | First write-back index |
| wr0_data | output | 32 | First write-back value |
| wr1_en | output | 1 | Second write-back enable |
| wr1_idx | output | 5 | Second write-back index |
| wr1_data | output | 32 | Second write-back value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target address |
| div_zero | output | 1 | Divide-by-zero exception |

## Verification
On every cycle the assertions check the handshake and the shape of the result bundle. `busy` and `done` never overlap, and `done` only follows an issue or a running operation. A second write always comes paired with a first write and `done`. A taken branch implies `done`, and a divide-by-zero never carries a write. Whether the numbers are correct can only be shown by the bench's scenarios. These cover every arithmetic result, product and quotient against a behavioural model, each branch condition on zero, negative and extreme operands, the signed offset targets, the link value, and the refusal of an issue during a running multiply.

// File: rtl/rx_exec_unit.sv
module rx_exec_unit #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      op,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [RIDX-1:0] ra_idx,
  input  logic [RIDX-1:0] rb_idx,
  input  logic [9:0]      imm,
  input  logic [XLEN-1:0] pc,
  output logic            busy,
  output logic            done,
  output logic            wr0_en,
  output logic [RIDX-1:0] wr0_idx,
  output logic [XLEN-1:0] wr0_data,
  output logic            wr1_en,
  output logic [RIDX-1:0] wr1_idx,
  output logic [XLEN-1:0] wr1_data,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic            div_zero
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  logic            go;
  logic [XLEN-1:0] opb, off5, off10, link;
  logic            s_we, s_take, s_md, s_dz, cond;
  logic [XLEN-1:0] s_data, s_tgt;

  logic [XLEN-1:0] hi, lo, dv;
  logic [CW-1:0]   cnt;
  logic            is_div;
  logic [RIDX-1:0] sv_ia, sv_ib;
  logic [XLEN:0]   msum, dsh, ddif;
  logic            dge;
  logic [XLEN-1:0] nhi, nlo;

  assign go    = start && !busy;
  assign opb   = op[3] ? {{(XLEN-5){1'b0}}, imm[4:0]} : rb_val;
  assign off5  = {{(XLEN-6){imm[4]}}, imm[4:0], 1'b0};
  assign off10 = {{(XLEN-11){imm[9]}}, imm, 1'b0};
  assign link  = pc + XLEN'(2);

  always_comb begin
    case (op[2:0])
      3'd0:    cond = (ra_val == '0);
      3'd1:    cond = (ra_val != '0);
      3'd2:    cond = ra_val[XLEN-1];
      3'd3:    cond = !ra_val[XLEN-1] && (ra_val != '0);
      3'd4:    cond = ra_val[XLEN-1] || (ra_val == '0);
      3'd5:    cond = !ra_val[XLEN-1];
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    s_we = 1'b0; s_data = '0; s_take = 1'b0; s_tgt = '0; s_md = 1'b0; s_dz = 1'b0;
    case (op)
      6'h20, 6'h28: begin s_we = 1'b1; s_data = ra_val + opb; end
      6'h21, 6'h29: begin s_we = 1'b1; s_data = ra_val - opb; end
      6'h22, 6'h2A: begin s_we = 1'b1; s_data = ra_val & opb; end
      6'h23:        begin s_we = 1'b1; s_data = ra_val | rb_val; end
      6'h24:        begin s_we = 1'b1; s_data = ra_val ^ rb_val; end
      6'h25:        begin s_we = 1'b1; s_data = ~rb_val; end
      6'h2D:        begin s_we = 1'b1; s_data = rb_val; end
      6'h26, 6'h2E: begin s_we = 1'b1; s_data = ra_val << opb[4:0]; end
      6'h27, 6'h2F: begin s_we = 1'b1; s_data = ra_val >> opb[4:0]; end
      6'h2B:        s_md = 1'b1;
      6'h2C:        if (rb_val == '0) s_dz = 1'b1; else s_md = 1'b1;
      6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15:
                    begin s_take = cond; s_tgt = rb_val; end
      6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D:
                    begin s_take = cond; s_tgt = pc + off5; end
      6'h16:        begin s_take = 1'b1; s_tgt = rb_val; end
      6'h1E:        begin s_take = 1'b1; s_tgt = pc + off10; end
      6'h17:        begin s_take = 1'b1; s_tgt = rb_val; s_we = 1'b1; s_data = link; end
      6'h1F:        begin s_take = 1'b1; s_tgt = pc + off5; s_we = 1'b1; s_data = link; end
      default: ;
    endcase
  end

  assign msum = {1'b0, hi} + (lo[0] ? {1'b0, dv} : '0);
  assign dsh  = {hi, lo[XLEN-1]};
  assign ddif = dsh - {1'b0, dv};
  assign dge  = (dsh >= {1'b0, dv});
  assign nhi  = is_div ? (dge ? ddif[XLEN-1:0] : dsh[XLEN-1:0]) : msum[XLEN:1];
  assign nlo  = is_div ? {lo[XLEN-2:0], dge} : {msum[0], lo[XLEN-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; is_div <= 1'b0;
      hi <= '0; lo <= '0; dv <= '0; sv_ia <= '0; sv_ib <= '0;
      wr0_en <= 1'b0; wr0_idx <= '0; wr0_data <= '0;
      wr1_en <= 1'b0; wr1_idx <= '0; wr1_data <= '0;
      br_taken <= 1'b0; br_target <= '0; div_zero <= 1'b0;
    end else begin
      done <= 1'b0; wr0_en <= 1'b0; wr1_en <= 1'b0;
      br_taken <= 1'b0; div_zero <= 1'b0;
      if (busy) begin
        hi  <= nhi;
        lo  <= nlo;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          wr0_en   <= 1'b1;
          wr1_en   <= 1'b1;
          wr0_idx  <= sv_ia;
          wr1_idx  <= sv_ib;
          wr0_data <= is_div ? nlo : nhi;
          wr1_data <= is_div ? nhi : nlo;
        end
      end else if (go) begin
        if (s_md) begin
          busy   <= 1'b1;
          cnt    <= '0;
          is_div <= (op == 6'h2C);
          hi     <= '0;
          lo     <= ra_val;
          dv     <= rb_val;
          sv_ia  <= ra_idx;
          sv_ib  <= rb_idx;
        end else begin
          done      <= 1'b1;
          wr0_en    <= s_we;
          wr0_idx   <= ra_idx;
          wr0_data  <= s_data;
          br_taken  <= s_take;
          br_target <= s_tgt;
          div_zero  <= s_dz;
        end
      end
    end
  end

  a_r4_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r1_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start || busy));
  a_r6_dz_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && !wr0_en && !wr1_en && !br_taken));
  a_r4_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> (wr0_en && done && !br_taken));
  a_r7_taken_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> done);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
endmodule

// File: tb/tb_rx_exec_unit.sv
module tb_rx_exec_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        w0; logic [4:0] i0; logic [31:0] d0;
    logic        w1; logic [4:0] i1; logic [31:0] d1;
    logic        tk; logic [31:0] tg; logic dz;
  } res_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [5:0] op = '0;
  logic [31:0] ra_val = '0, rb_val = '0, pc = '0;
  logic [4:0] ra_idx = '0, rb_idx = '0;
  logic [9:0] imm = '0;
  logic busy, done, wr0_en, wr1_en, br_taken, div_zero;
  logic [4:0] wr0_idx, wr1_idx;
  logic [31:0] wr0_data, wr1_data, br_target;

  int n_tests = 0, n_fail = 0;

  rx_exec_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .ra_val(ra_val),
    .rb_val(rb_val), .ra_idx(ra_idx), .rb_idx(rb_idx), .imm(imm), .pc(pc), .busy(busy),
    .done(done), .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data), .wr1_en(wr1_en),
    .wr1_idx(wr1_idx), .wr1_data(wr1_data), .br_taken(br_taken), .br_target(br_target),
    .div_zero(div_zero));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(logic [5:0] o);
    if (o == 6'h2B) return "R4";
    if (o == 6'h2C) return "R5";
    if (o inside {6'h26, 6'h27, 6'h2E, 6'h2F}) return "R3";
    if (o[5:4] == 2'b10) return "R2";
    if (o inside {6'h16, 6'h1E}) return "R8";
    if (o inside {6'h17, 6'h1F}) return "R9";
    if (o[5:4] == 2'b01) return "R7";
    return "R11";
  endfunction

  function automatic res_t model(logic [5:0] o, logic [31:0] a, logic [31:0] b,
                                 logic [4:0] ia, logic [4:0] ib, logic [9:0] im, logic [31:0] p);
    res_t r = '0;
    logic [31:0] bo = o[3] ? {27'b0, im[4:0]} : b;
    logic [31:0] o5 = {{26{im[4]}}, im[4:0], 1'b0};
    logic [31:0] o10 = {{21{im[9]}}, im, 1'b0};
    logic [63:0] pr;
    logic c;
    r.i0 = ia;
    case (o[2:0])
      3'd0: c = (a == 0);
      3'd1: c = (a != 0);
      3'd2: c = ($signed(a) < 0);
      3'd3: c = ($signed(a) > 0);
      3'd4: c = ($signed(a) <= 0);
      3'd5: c = ($signed(a) >= 0);
      default: c = 0;
    endcase
    case (o)
      6'h20, 6'h28: begin r.w0 = 1; r.d0 = a + bo; end
      6'h21, 6'h29: begin r.w0 = 1; r.d0 = a - bo; end
      6'h22, 6'h2A: begin r.w0 = 1; r.d0 = a & bo; end
      6'h23: begin r.w0 = 1; r.d0 = a | b; end
      6'h24: begin r.w0 = 1; r.d0 = a ^ b; end
      6'h25: begin r.w0 = 1; r.d0 = ~b; end
      6'h2D: begin r.w0 = 1; r.d0 = b; end
      6'h26, 6'h2E: begin r.w0 = 1; r.d0 = a << bo[4:0]; end
      6'h27, 6'h2F: begin r.w0 = 1; r.d0 = a >> bo[4:0]; end
      6'h2B: begin pr = {32'b0, a} * {32'b0, b};
        r.w0 = 1; r.d0 = pr[63:32]; r.w1 = 1; r.i1 = ib; r.d1 = pr[31:0]; end
      6'h2C: if (b == 0) r.dz = 1;
             else begin r.w0 = 1; r.d0 = a / b; r.w1 = 1; r.i1 = ib; r.d1 = a % b; end
      6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15: begin r.tk = c; r.tg = b; end
      6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D: begin r.tk = c; r.tg = p + o5; end
      6'h16: begin r.tk = 1; r.tg = b; end
      6'h1E: begin r.tk = 1; r.tg = p + o10; end
      6'h17: begin r.tk = 1; r.tg = b; r.w0 = 1; r.d0 = p + 2; end
      6'h1F: begin r.tk = 1; r.tg = p + o5; r.w0 = 1; r.d0 = p + 2; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic res_t norm(res_t x);
    res_t y = x;
    if (!y.w0) begin y.i0 = '0; y.d0 = '0; end
    if (!y.w1) begin y.i1 = '0; y.d1 = '0; end
    if (!y.tk) y.tg = '0;
    return y;
  endfunction

  task automatic run_op(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] ia, input logic [4:0] ib, input logic [9:0] im,
                        input logic [31:0] p);
    res_t exp, got;
    int w = 0;
    @(negedge clk);
    op = o; ra_val = a; rb_val = b; ra_idx = ia; rb_idx = ib; imm = im; pc = p; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && w < 100) begin @(negedge clk); w++; end
    exp = norm(model(o, a, b, ia, ib, im, p));
    got = norm({wr0_en, wr0_idx, wr0_data, wr1_en, wr1_idx, wr1_data, br_taken, br_target, div_zero});
    n_tests++;
    if (!done || got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h done=%b got=%h exp=%h", tag_of(o), o, a, b, done, got, exp);
    end
    if (o != 6'h2B && o != 6'h2C && w != 0) begin
      n_fail++;
      $display("FAIL R2 latency op=%h actual=%0d expected=0", o, w);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    n_tests++;
    if (done || busy || wr0_en || wr1_en || br_taken || div_zero) begin
      n_fail++;
      $display("FAIL R1 reset state actual=%b expected=000000",
               {done, busy, wr0_en, wr1_en, br_taken, div_zero});
    end
    rst_n = 1;
    // R2 directed, imm forms
    run_op(6'h20, 32'hFFFF_FFFF, 32'h2, 5'd3, 5'd4, 10'h0, 32'h0);
    run_op(6'h29, 32'h10, 32'h999, 5'd7, 5'd8, 10'h1F, 32'h0);
    run_op(6'h25, 32'h1, 32'h0F0F_0F0F, 5'd1, 5'd2, 10'h0, 32'h0);
    // R3 shift amount masks to 5 bits
    run_op(6'h26, 32'h8000_0001, 32'h21, 5'd5, 5'd6, 10'h0, 32'h0);
    run_op(6'h27, 32'h8000_0000, 32'h0, 5'd5, 5'd6, 10'h1F, 32'h0);
    run_op(6'h2F, 32'h8000_0000, 32'h0, 5'd5, 5'd6, 10'h1F, 32'h0);
    // R4 / R5 / R6 corners
    run_op(6'h2B, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd9, 5'd10, 10'h0, 32'h0);
    run_op(6'h2C, 32'hFFFF_FFFF, 32'h7, 5'd11, 5'd12, 10'h0, 32'h0);
    run_op(6'h2C, 32'h5, 32'h9, 5'd11, 5'd12, 10'h0, 32'h0);
    run_op(6'h2C, 32'h1234, 32'h0, 5'd11, 5'd12, 10'h0, 32'h0);
    // R7 conditions on zero, negative, positive
    for (int k = 0; k < 6; k++) begin
      run_op(6'h10 + 6'(k), 32'h0, 32'hA0, 5'd1, 5'd2, 10'h0, 32'h100);
      run_op(6'h18 + 6'(k), 32'h8000_0000, 32'hA0, 5'd1, 5'd2, 10'h10, 32'h100);
      run_op(6'h18 + 6'(k), 32'h7FFF_FFFF, 32'hA0, 5'd1, 5'd2, 10'h0F, 32'h100);
    end
    // R8 / R9
    run_op(6'h16, 32'h0, 32'h4000, 5'd0, 5'd31, 10'h0, 32'h200);
    run_op(6'h1E, 32'h0, 32'h0, 5'd0, 5'd0, 10'h200, 32'h2000);
    run_op(6'h17, 32'h0, 32'h8000, 5'd31, 5'd3, 10'h0, 32'h300);
    run_op(6'h1F, 32'h0, 32'h0, 5'd31, 5'd3, 10'h1E, 32'h300);
    // R11 undefined opcodes
    run_op(6'h00, 32'h1, 32'h2, 5'd1, 5'd2, 10'h3FF, 32'h0);
    run_op(6'h3A, 32'h1, 32'h2, 5'd1, 5'd2, 10'h3FF, 32'h0);
    // R10: issue during a running MUL is refused
    begin
      int dones = 0;
      @(negedge clk);
      op = 6'h2B; ra_val = 32'h10000; rb_val = 32'h30000; ra_idx = 5'd4; rb_idx = 5'd5; start = 1;
      @(negedge clk);
      op = 6'h20; ra_val = 32'h1; rb_val = 32'h1; ra_idx = 5'd9;
      repeat (5) @(negedge clk);
      start = 0;
      for (int c = 0; c < 40; c++) begin
        if (done) begin
          dones++;
          n_tests++;
          if (!(wr0_idx == 5'd4 && wr0_data == 32'h3 && wr1_data == 32'h0)) begin
            n_fail++;
            $display("FAIL R10 result actual=%0d:%h:%h expected=4:3:0", wr0_idx, wr0_data, wr1_data);
          end
        end
        @(negedge clk);
      end
      n_tests++;
      if (dones != 1) begin
        n_fail++;
        $display("FAIL R10 done count actual=%0d expected=1", dones);
      end
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] o;
      o = 6'($urandom % 64);
      run_op(o, pick(), pick(), 5'($urandom), 5'($urandom), 10'($urandom), $urandom & 32'hFFFF_FFFE);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule